// File: doc/BRIEF.md
# Shared Dual-Pipe Floating-Point Issue Arbiter

This block sits between two integer cores and a pair of 128-bit floating-point execution pipes. In every clock cycle it looks at what each core is offering and decides how to split the two pipes between them. It then steers each granted operation onto a pipe and answers each core with a ready or a stall. No static configuration fixes the split. Each pipe takes one operation per cycle of any type: fused multiply-add, add or multiply. Because of this, the kind of arithmetic never limits which pipe gets picked.

A core offers at most one request per cycle. The request has one of three shapes: a single 128-bit operation, a pair of independent 128-bit operations, or one 256-bit operation, which is split into a low half and a high half. There are four ways a cycle can resolve:
- One core takes both pipes.
- Each core takes one pipe.
- A pair is split across two cycles.
- Nothing issues.

Every pipe output carries the owning core number and a high-half tag, so that results can be routed back and 256-bit halves joined again. When the cores contend, a round-robin pointer chooses the winner.

The handshake is combinational within the cycle. A core holds its valid request stable until ready is high. The pipe issue signals are valid in the same cycle as the grant.

Top module: `fpa_issue_arbiter`

## Requirements
- R1: A 256-bit request (kind code 2) that is accepted drives both pipes in the same cycle with the requesting core's number. Operand A goes on pipe 0 with the high tag low, and operand B goes on pipe 1 with the high tag high.
- R2: A pair request (kind code 1) from a core that is alone is accepted in one cycle. Operand A goes on pipe 0 and operand B on pipe 1, both with the high tag low.
- R3: When both cores request and each needs only one pipe, both are accepted in that cycle. Core 0 goes on pipe 0 and core 1 on pipe 1.
- R4: A lone request that needs one pipe issues on pipe 0, and pipe 1 stays invalid.
- R5: When both cores request and at least one needs both pipes, the core the round-robin pointer favours wins and the other sees ready low. After reset the pointer favours core 0 (parameter INIT_PRIO). It passes to the other core only after the favoured core is accepted in such a contended cycle.
- R6: A pair that loses contention to a one-pipe winner has operand A issued on the free pipe in that cycle, with ready low and the partial flag high. In the next cycle, with the request held, operand B issues and ready goes high. Operand B never issues before operand A.
- R7: With no valid request, both pipe valids are low and the idle output is high. With zeroing enabled (GATE_IDLE_OPS=1), an invalid pipe's operand bus is all zeros.
- R8: Kind code 3 is handled exactly like kind code 0 (a single operation).
- R9: Ready is never high without valid, and the partial flag is never high together with ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 2 | Request valid, one bit per core |
| core_kind | input | 4 | Request shape, 2 bits per core (0 single, 1 pair, 2 wide, 3 single) |
| core_op_a | input | 2*OP_W | First operand or low half, OP_W bits per core |
| core_op_b | input | 2*OP_W | Second operand or high half, OP_W bits per core |
| core_ready | output | 2 | Request fully accepted this cycle |
| core_part | output | 2 | First operation of a pair accepted, second still pending |
| pipe_vld | output | 2 | Pipe issue valid, one bit per pipe |
| pipe_op | output | 2*OP_W | Operand issued to each pipe |
| pipe_core | output | 2 | Owning core of each pipe's operation |
| pipe_hi | output | 2 | Operation is the high half of a 256-bit request |
| pipes_idle | output | 1 | No pipe issues this cycle |

## Verification
The bench builds the arbiter with OP_W of 16, INIT_PRIO of 0 and the zeroing variant selected. Each core and each operand slot gets its own 16-bit pattern, so a steering mistake between cores, slots or halves shows up directly on the pipe buses. Zeroing makes the bus of an unused pipe observable. Starting the pointer at core 0 fixes which core must win the first contended cycle, and the sequence of scenarios then tracks the pointer through a win, a hand-over and a split pair.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   typedef enum logic [1:0] {
      KIND_ONE  = 2'd0,
      KIND_PAIR = 2'd1,
      KIND_WIDE = 2'd2,
      KIND_RSVD = 2'd3
   } req_kind_e;

   localparam int unsigned N_CORES = 2;
   localparam int unsigned N_PIPES = 2;

   typedef struct packed {
      logic vld;
      logic core;
      logic use_b;
      logic hi;
   } pipe_sel_t;
endpackage

// File: rtl/fpa_req_decode.sv
module fpa_req_decode #(
   parameter int unsigned OP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic [1:0]      kind,
   input  logic [OP_W-1:0] op_a,
   input  logic [OP_W-1:0] op_b,
   input  logic            grant_full,
   input  logic            grant_part,
   output logic            active,
   output logic            need_two,
   output logic            is_wide,
   output logic [OP_W-1:0] cur_op
);
   import fpa_pkg::*;

   logic half_done;
   logic is_pair;

   assign is_wide  = (kind == KIND_WIDE);
   assign is_pair  = (kind == KIND_PAIR);
   assign active   = valid;
   assign need_two = valid & (is_wide | (is_pair & ~half_done));
   assign cur_op   = (is_pair & half_done) ? op_b : op_a;

   always_ff @(posedge clk) begin
      if (!rst_n)          half_done <= 1'b0;
      else if (grant_part) half_done <= 1'b1;
      else if (grant_full) half_done <= 1'b0;
   end
endmodule

// File: rtl/fpa_rr_ptr.sv
module fpa_rr_ptr #(
   parameter int unsigned INIT_PRIO = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_done,
   output logic ptr
);
   localparam logic RESET_VAL = (INIT_PRIO != 0);

   always_ff @(posedge clk) begin
      if (!rst_n)        ptr <= RESET_VAL;
      else if (win_done) ptr <= ~ptr;
   end
endmodule

// File: rtl/fpa_steer.sv
module fpa_steer (
   input  logic               ptr,
   input  logic [1:0]         active,
   input  logic [1:0]         need_two,
   input  logic [1:0]         is_wide,
   output logic [1:0]         full,
   output logic [1:0]         part,
   output fpa_pkg::pipe_sel_t sel [2],
   output logic               win_done
);
   import fpa_pkg::*;

   logic both, conflict, lone, win, lose;

   assign both     = active[0] & active[1];
   assign conflict = both & (need_two[0] | need_two[1]);
   assign lone     = active[1] & ~active[0];
   assign win      = ptr;
   assign lose     = ~ptr;
   assign win_done = conflict & full[win];

   always_comb begin
      full = '0;
      part = '0;
      for (int p = 0; p < 2; p++) sel[p] = '0;
      if (!both) begin
         if (active != 2'b00) begin
            full[lone]    = 1'b1;
            sel[0].vld    = 1'b1;
            sel[0].core   = lone;
            if (need_two[lone]) begin
               sel[1].vld   = 1'b1;
               sel[1].core  = lone;
               sel[1].use_b = 1'b1;
               sel[1].hi    = is_wide[lone];
            end
         end
      end else if (!conflict) begin
         full        = 2'b11;
         sel[0].vld  = 1'b1;
         sel[0].core = 1'b0;
         sel[1].vld  = 1'b1;
         sel[1].core = 1'b1;
      end else begin
         full[win] = 1'b1;
         if (need_two[win]) begin
            sel[0].vld   = 1'b1;
            sel[0].core  = win;
            sel[1].vld   = 1'b1;
            sel[1].core  = win;
            sel[1].use_b = 1'b1;
            sel[1].hi    = is_wide[win];
         end else if (!is_wide[lose]) begin
            part[lose]      = 1'b1;
            sel[win].vld    = 1'b1;
            sel[win].core   = win;
            sel[lose].vld   = 1'b1;
            sel[lose].core  = lose;
         end else begin
            sel[0].vld  = 1'b1;
            sel[0].core = win;
         end
      end
   end
endmodule

// File: rtl/fpa_issue_arbiter.sv
module fpa_issue_arbiter #(
   parameter int unsigned OP_W          = 16,
   parameter int unsigned INIT_PRIO     = 0,
   parameter int unsigned GATE_IDLE_OPS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        core_valid,
   input  logic [3:0]        core_kind,
   input  logic [2*OP_W-1:0] core_op_a,
   input  logic [2*OP_W-1:0] core_op_b,
   output logic [1:0]        core_ready,
   output logic [1:0]        core_part,
   output logic [1:0]        pipe_vld,
   output logic [2*OP_W-1:0] pipe_op,
   output logic [1:0]        pipe_core,
   output logic [1:0]        pipe_hi,
   output logic              pipes_idle
);
   import fpa_pkg::*;

   if (OP_W < 1) begin : g_bad_width
      $error("fpa_issue_arbiter: OP_W must be at least 1");
   end
   if (INIT_PRIO > 1) begin : g_bad_prio
      $error("fpa_issue_arbiter: INIT_PRIO must be 0 or 1");
   end
   if (GATE_IDLE_OPS > 1) begin : g_bad_gate
      $error("fpa_issue_arbiter: GATE_IDLE_OPS must be 0 or 1");
   end

   logic [1:0]      active, need_two, is_wide, full, part;
   logic [OP_W-1:0] cur_op [N_CORES];
   logic [OP_W-1:0] opb    [N_CORES];
   pipe_sel_t       sel    [N_PIPES];
   logic            ptr, win_done;

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign opb[c] = core_op_b[c*OP_W +: OP_W];
      fpa_req_decode #(.OP_W(OP_W)) u_dec (
         .clk        (clk),
         .rst_n      (rst_n),
         .valid      (core_valid[c]),
         .kind       (core_kind[2*c +: 2]),
         .op_a       (core_op_a[c*OP_W +: OP_W]),
         .op_b       (opb[c]),
         .grant_full (full[c]),
         .grant_part (part[c]),
         .active     (active[c]),
         .need_two   (need_two[c]),
         .is_wide    (is_wide[c]),
         .cur_op     (cur_op[c])
      );
   end

   fpa_rr_ptr #(.INIT_PRIO(INIT_PRIO)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_done (win_done),
      .ptr      (ptr)
   );

   fpa_steer u_steer (
      .ptr      (ptr),
      .active   (active),
      .need_two (need_two),
      .is_wide  (is_wide),
      .full     (full),
      .part     (part),
      .sel      (sel),
      .win_done (win_done)
   );

   assign core_ready = full;
   assign core_part  = part;

   for (genvar p = 0; p < N_PIPES; p++) begin : g_pipe
      logic [OP_W-1:0] raw_op;
      assign raw_op       = sel[p].use_b ? opb[sel[p].core] : cur_op[sel[p].core];
      assign pipe_vld[p]  = sel[p].vld;
      assign pipe_core[p] = sel[p].core;
      assign pipe_hi[p]   = sel[p].hi;
      if (GATE_IDLE_OPS != 0) begin : g_gated
         assign pipe_op[p*OP_W +: OP_W] = sel[p].vld ? raw_op : '0;
      end else begin : g_open
         assign pipe_op[p*OP_W +: OP_W] = raw_op;
      end
   end

   assign pipes_idle = ~(pipe_vld[0] | pipe_vld[1]);
endmodule

// File: rtl/fpa_issue_checker.sv
module fpa_issue_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] core_valid,
   input logic [3:0] core_kind,
   input logic [1:0] core_ready,
   input logic [1:0] core_part,
   input logic [1:0] pipe_vld,
   input logic [1:0] pipe_core,
   input logic [1:0] pipe_hi,
   input logic       pipes_idle
);
   logic single0, single1;
   assign single0 = (core_kind[1:0] == 2'd0) || (core_kind[1:0] == 2'd3);
   assign single1 = (core_kind[3:2] == 2'd0) || (core_kind[3:2] == 2'd3);

   for (genvar c = 0; c < 2; c++) begin : g_chk
      AST_WIDE_BOTH_PIPES: assert property (@(posedge clk) disable iff (!rst_n)
         (core_ready[c] && core_kind[2*c +: 2] == 2'd2) |->
         (pipe_vld == 2'b11 && pipe_core == {2{1'(c)}} && pipe_hi == 2'b10)); // R1
      AST_PART_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
         core_part[c] |=> !core_part[c]); // R6
   end

   AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ((core_ready & ~core_valid) == 2'b00) && ((core_part & core_ready) == 2'b00)); // R9
   AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid == 2'b00) |-> (pipe_vld == 2'b00 && pipes_idle)); // R7
   AST_SPLIT_SINGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid == 2'b11 && single0 && single1) |->
      (core_ready == 2'b11 && pipe_core == 2'b10)); // R3
endmodule

bind fpa_issue_arbiter fpa_issue_checker u_fpa_issue_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_valid (core_valid),
   .core_kind  (core_kind),
   .core_ready (core_ready),
   .core_part  (core_part),
   .pipe_vld   (pipe_vld),
   .pipe_core  (pipe_core),
   .pipe_hi    (pipe_hi),
   .pipes_idle (pipes_idle)
);

// File: tb/fpa_issue_arbiter_bench.sv
`timescale 1ns/1ps
module fpa_issue_arbiter_bench;
   localparam int unsigned OP_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        core_valid = '0;
   logic [3:0]        core_kind = '0;
   logic [2*OP_W-1:0] core_op_a = '0;
   logic [2*OP_W-1:0] core_op_b = '0;
   logic [1:0]        core_ready, core_part, pipe_vld, pipe_core, pipe_hi;
   logic [2*OP_W-1:0] pipe_op;
   logic              pipes_idle;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   fpa_issue_arbiter #(.OP_W(OP_W), .INIT_PRIO(0), .GATE_IDLE_OPS(1)) u_fpa_issue_arbiter (
      .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_kind(core_kind),
      .core_op_a(core_op_a), .core_op_b(core_op_b), .core_ready(core_ready),
      .core_part(core_part), .pipe_vld(pipe_vld), .pipe_op(pipe_op),
      .pipe_core(pipe_core), .pipe_hi(pipe_hi), .pipes_idle(pipes_idle)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v0, input logic [1:0] k0, input logic [15:0] a0, input logic [15:0] b0,
                        input logic v1, input logic [1:0] k1, input logic [15:0] a1, input logic [15:0] b1);
      @(negedge clk);
      core_valid = {v1, v0};
      core_kind  = {k1, k0};
      core_op_a  = {a1, a0};
      core_op_b  = {b1, b0};
      #2;
   endtask

   task automatic t_reset;
      chk(pipe_vld == 2'b00, "R7 reset vld", 64'(pipe_vld), 64'h0);
      chk(pipes_idle == 1'b1, "R7 reset idle", 64'(pipes_idle), 64'h1);
      chk(core_ready == 2'b00, "R9 reset ready", 64'(core_ready), 64'h0);
   endtask

   task automatic t_lone_single;
      drive(0, 0, 0, 0, 1, 2'd0, 16'h5A01, 16'h5A02);
      chk(pipe_vld == 2'b01, "R4 lone vld", 64'(pipe_vld), 64'h1);
      chk(pipe_op == 32'h0000_5A01, "R4 R7 lone op", 64'(pipe_op), 64'h5A01);
      chk(pipe_core[0] == 1'b1, "R4 lone core", 64'(pipe_core), 64'h1);
      chk(core_ready == 2'b10, "R4 lone ready", 64'(core_ready), 64'h2);
      drive(0, 0, 0, 0, 1, 2'd3, 16'h5B01, 16'h5B02);
      chk(pipe_vld == 2'b01 && pipe_op == 32'h0000_5B01, "R8 code3 single", 64'(pipe_op), 64'h5B01);
      chk(core_ready == 2'b10 && core_part == 2'b00, "R8 code3 ready", 64'(core_ready), 64'h2);
   endtask

   task automatic t_lone_pair;
      drive(1, 2'd1, 16'h1A1A, 16'h1B1B, 0, 0, 0, 0);
      chk(pipe_vld == 2'b11 && pipe_core == 2'b00, "R2 pair pipes", 64'({pipe_vld, pipe_core}), 64'hC);
      chk(pipe_op == 32'h1B1B_1A1A, "R2 pair ops", 64'(pipe_op), 64'h1B1B1A1A);
      chk(pipe_hi == 2'b00 && core_ready == 2'b01, "R2 pair hi ready", 64'({pipe_hi, core_ready}), 64'h1);
   endtask

   task automatic t_wide;
      drive(0, 0, 0, 0, 1, 2'd2, 16'h2C00, 16'h2C11);
      chk(pipe_op == 32'h2C11_2C00, "R1 wide halves", 64'(pipe_op), 64'h2C112C00);
      chk(pipe_hi == 2'b10 && pipe_core == 2'b11, "R1 wide tags", 64'({pipe_hi, pipe_core}), 64'hB);
      chk(core_ready == 2'b10, "R1 wide ready", 64'(core_ready), 64'h2);
   endtask

   task automatic t_split;
      drive(1, 2'd0, 16'h0D0D, 16'h0, 1, 2'd0, 16'h1D1D, 16'h0);
      chk(core_ready == 2'b11, "R3 split ready", 64'(core_ready), 64'h3);
      chk(pipe_op == 32'h1D1D_0D0D && pipe_core == 2'b10, "R3 split steer", 64'(pipe_op), 64'h1D1D0D0D);
   endtask

   task automatic t_conflict;
      drive(1, 2'd2, 16'h00A1, 16'h00A2, 1, 2'd2, 16'h00B1, 16'h00B2);
      chk(core_ready == 2'b01, "R5 first winner core0", 64'(core_ready), 64'h1);
      chk(pipe_op == 32'h00A2_00A1 && pipe_core == 2'b00, "R5 winner ops", 64'(pipe_op), 64'h00A200A1);
      drive(1, 2'd2, 16'h00C1, 16'h00C2, 1, 2'd2, 16'h00B1, 16'h00B2);
      chk(core_ready == 2'b10, "R5 pointer hands over", 64'(core_ready), 64'h2);
      chk(pipe_op == 32'h00B2_00B1 && pipe_core == 2'b11, "R5 second winner ops", 64'(pipe_op), 64'h00B200B1);
      drive(1, 2'd2, 16'h00C1, 16'h00C2, 0, 0, 0, 0);
      chk(core_ready == 2'b01 && pipe_op == 32'h00C2_00C1, "R5 held loser served", 64'(pipe_op), 64'h00C200C1);
   endtask

   task automatic t_partial;
      drive(1, 2'd0, 16'h0A0A, 16'h0, 1, 2'd1, 16'h1111, 16'h2222);
      chk(core_ready == 2'b01 && core_part == 2'b10, "R6 partial flags", 64'({core_ready, core_part}), 64'h6);
      chk(pipe_op == 32'h1111_0A0A, "R6 first op only", 64'(pipe_op), 64'h11110A0A);
      chk(pipe_core == 2'b10 && pipe_vld == 2'b11, "R6 partial steer", 64'({pipe_vld, pipe_core}), 64'hE);
      drive(0, 0, 0, 0, 1, 2'd1, 16'h1111, 16'h2222);
      chk(core_ready == 2'b10 && core_part == 2'b00, "R6 second completes", 64'({core_ready, core_part}), 64'h8);
      chk(pipe_vld == 2'b01 && pipe_op == 32'h0000_2222, "R6 second op", 64'(pipe_op), 64'h2222);
   endtask

   task automatic t_idle;
      drive(0, 2'd2, 16'hFFFF, 16'hFFFF, 0, 2'd1, 16'hEEEE, 16'hEEEE);
      chk(pipe_vld == 2'b00 && pipes_idle, "R7 idle", 64'({pipe_vld, pipes_idle}), 64'h1);
      chk(pipe_op == '0 && core_ready == 2'b00, "R7 R9 idle bus", 64'(pipe_op), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2 t_reset();
      @(negedge clk) rst_n = 1'b1;
      #2 t_reset();
      t_lone_single();
      t_lone_pair();
      t_wide();
      t_split();
      t_conflict();
      t_partial();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule